// File: doc/BRIEF.md
# Interlaced Two-Level Cache Configuration Search Engine

This block searches for a low-energy cache configuration for a processor with separate instruction and data paths. Each path has its own first-level (L1) and second-level (L2) cache. After a start pulse the engine proposes one candidate at a time on four configuration words. It raises a measurement request and waits for an external energy estimate for that candidate. It keeps the cheapest candidate seen so far. When both paths are finished it leaves the winning configurations on its outputs and raises done. The energy estimator and the caches lie outside the block.

A configuration word holds three codes, each 2 bits wide: total size, line size and way count. Code k means 2^k times the smallest option of that parameter. The search sweeps one field at a time, in order of energy impact, and alternates between the two levels. After the sweeps it runs a short neighbourhood search. That search recovers cases where a sweep could not pass a size whose way count was illegal. The instruction path is tuned completely before the data path. A limit input gives, for each size code, the largest way code the cache supports. Any candidate that breaks a limit is skipped without a measurement.

Top module: `cache_tuner`

## Requirements
- R1: While reset is high and after it is released, done_o and meas_req_o are 0. Both L1 words read 0. Both L2 words read the start point: size code L2_SIZE0=2, line code L2_LINE0=2, way code L2_WAYS0=2.
- R2: A configuration word is {size[5:4], line[3:2], ways[1:0]}. While meas_req_o is high and energy_vld_i is low, the request stays high and all four words stay stable. energy_vld_i has no effect while meas_req_o is low.
- R3: On each path the sweeps run in this order: L1 size, L2 size, L1 line, L2 line, L1 ways, L2 ways. Each sweep steps its field from code 0 upward. All other fields stay at the best configuration found so far.
- R4: A sweep ends after the first measured energy that is strictly greater than the best energy before that measurement. Otherwise it ends after the largest code: 3 for size, 2 for line and ways.
- R5: A candidate is legal when, for both levels, its way code is no greater than the limit for its size code. The limit for size code s is bits [2s+1:2s] of l1_amax_i or l2_amax_i. An illegal candidate is never requested.
- R6: Energy is an unsigned 32-bit value. A candidate replaces the best only when its energy is strictly lower, so on a tie the earlier candidate stays.
- R7: After the sweeps, 16 neighbours of the current best are tried in index order k = 0..15. Bit 3 selects the level (0 = L1). Bits 2:1 select the move: 0 size, 1 line, 2 ways, 3 size and ways together. Bit 0 selects the direction (1 = up, 0 = down). Codes that fall out of range are skipped. This phase has no early stop.
- R8: A start pulse returns all four words to their R1 values. The instruction pair (l1i, l2i) is tuned first while the data words hold their R1 values. After that, the instruction words hold the instruction best while the data pair is tuned.
- R9: When the data path finishes, all four words show the best configurations and done_o goes high. done_o stays high until the next start. start_i is ignored while a search is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search (used only when idle) |
| energy_i | input | 32 | Energy of the candidate being measured |
| energy_vld_i | input | 1 | energy_i is valid; accepted only while a request is open |
| l1_amax_i | input | 8 | Largest L1 way code for each size code, 2 bits per size |
| l2_amax_i | input | 8 | Largest L2 way code for each size code, 2 bits per size |
| l1i_cfg_o | output | 6 | Instruction L1 configuration word |
| l2i_cfg_o | output | 6 | Instruction L2 configuration word |
| l1d_cfg_o | output | 6 | Data L1 configuration word |
| l2d_cfg_o | output | 6 | Data L2 configuration word |
| meas_req_o | output | 1 | Request: measure the configuration now on the words |
| done_o | output | 1 | Search complete; words hold the results |

## Verification
Two decisions land on the same clock edge when an energy value is accepted. One is whether the candidate becomes the new best. The other is whether the sweep ends. Both must use the best energy from before that edge. The bench provokes this with bowl-shaped energy surfaces whose minimum sits at a code edge, and with a flat surface where every value ties. It judges the outcome by comparing every requested configuration, in order, against an independent model of the search, then checking the request count and the final words. A stray valid pulse placed in the idle cycle right after each acceptance also checks that only an open request takes energy.

// File: rtl/ct_pkg.sv
`timescale 1ns/1ps
package ct_pkg;
  localparam int FW = 2;          // bits per configuration field
  localparam int CW = 3 * FW;     // configuration word width

  typedef struct packed {
    logic [FW-1:0] sz;   // total size code
    logic [FW-1:0] ln;   // line size code
    logic [FW-1:0] wy;   // way count code
  } cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_MEAS} st_t;
endpackage

// File: rtl/ct_legal_chk.sv
`timescale 1ns/1ps
module ct_legal_chk
  import ct_pkg::*;
#(
  parameter int N_SIZE = 4
) (
  input  cfg_t                   cfg_i,
  input  logic [N_SIZE*FW-1:0]   amax_i,
  output logic                   ok_o
);
  logic [FW-1:0] lim [N_SIZE];

  for (genvar s = 0; s < N_SIZE; s++) begin : g_sz
    assign lim[s] = amax_i[s*FW +: FW];
  end

  assign ok_o = (cfg_i.wy <= lim[cfg_i.sz]);
endmodule

// File: rtl/ct_cand_gen.sv
`timescale 1ns/1ps
module ct_cand_gen
  import ct_pkg::*;
#(
  parameter int N_SIZE  = 4,
  parameter int N_LINE  = 3,
  parameter int N_WAYS  = 3,
  parameter int N_SWEEP = 6
) (
  input  cfg_t        base1_i,
  input  cfg_t        base2_i,
  input  logic [2:0]  step_i,
  input  logic [4:0]  idx_i,
  output cfg_t        cand1_o,
  output cfg_t        cand2_o,
  output logic        over_o,
  output logic        range_ok_o
);
  localparam logic [4:0]  NSZ    = 5'(N_SIZE);
  localparam logic [4:0]  NLN    = 5'(N_LINE);
  localparam logic [4:0]  NWY    = 5'(N_WAYS);
  localparam logic [4:0]  NLOC   = 5'(2 * 4 * 2);
  localparam logic [FW:0] TOP_SZ = (FW+1)'(N_SIZE - 1);
  localparam logic [FW:0] TOP_LN = (FW+1)'(N_LINE - 1);
  localparam logic [FW:0] TOP_WY = (FW+1)'(N_WAYS - 1);

  cfg_t       pick, mod;
  logic       lvl, up;
  logic [1:0] fld;

  always_comb begin
    lvl        = 1'b0;
    up         = 1'b0;
    fld        = 2'd0;
    over_o     = 1'b0;
    range_ok_o = 1'b1;
    pick       = base1_i;
    mod        = base1_i;
    if (step_i < 3'(N_SWEEP)) begin
      lvl  = step_i[0];
      fld  = step_i[2:1];
      pick = lvl ? base2_i : base1_i;
      mod  = pick;
      case (fld)
        2'd0: begin over_o = (idx_i >= NSZ); mod.sz = idx_i[FW-1:0]; end
        2'd1: begin over_o = (idx_i >= NLN); mod.ln = idx_i[FW-1:0]; end
        2'd2: begin over_o = (idx_i >= NWY); mod.wy = idx_i[FW-1:0]; end
        default: over_o = 1'b1;
      endcase
    end else begin
      lvl    = idx_i[3];
      fld    = idx_i[2:1];
      up     = idx_i[0];
      over_o = (idx_i >= NLOC);
      pick   = lvl ? base2_i : base1_i;
      mod    = pick;
      if (fld == 2'd0 || fld == 2'd3) begin
        if (up) begin
          if ({1'b0, pick.sz} >= TOP_SZ) range_ok_o = 1'b0;
          mod.sz = pick.sz + 1'b1;
        end else begin
          if (pick.sz == '0) range_ok_o = 1'b0;
          mod.sz = pick.sz - 1'b1;
        end
      end
      if (fld == 2'd1) begin
        if (up) begin
          if ({1'b0, pick.ln} >= TOP_LN) range_ok_o = 1'b0;
          mod.ln = pick.ln + 1'b1;
        end else begin
          if (pick.ln == '0) range_ok_o = 1'b0;
          mod.ln = pick.ln - 1'b1;
        end
      end
      if (fld == 2'd2 || fld == 2'd3) begin
        if (up) begin
          if ({1'b0, pick.wy} >= TOP_WY) range_ok_o = 1'b0;
          mod.wy = pick.wy + 1'b1;
        end else begin
          if (pick.wy == '0) range_ok_o = 1'b0;
          mod.wy = pick.wy - 1'b1;
        end
      end
    end
  end

  assign cand1_o = lvl ? base1_i : mod;
  assign cand2_o = lvl ? mod : base2_i;
endmodule

// File: rtl/cache_tuner.sv
`timescale 1ns/1ps
module cache_tuner
  import ct_pkg::*;
#(
  parameter int EW       = 32,
  parameter int N_SIZE   = 4,
  parameter int N_LINE   = 3,
  parameter int N_WAYS   = 3,
  parameter int L2_SIZE0 = 2,
  parameter int L2_LINE0 = 2,
  parameter int L2_WAYS0 = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [EW-1:0]        energy_i,
  input  logic                 energy_vld_i,
  input  logic [N_SIZE*FW-1:0] l1_amax_i,
  input  logic [N_SIZE*FW-1:0] l2_amax_i,
  output logic [CW-1:0]        l1i_cfg_o,
  output logic [CW-1:0]        l2i_cfg_o,
  output logic [CW-1:0]        l1d_cfg_o,
  output logic [CW-1:0]        l2d_cfg_o,
  output logic                 meas_req_o,
  output logic                 done_o
);
  localparam int         N_SWEEP    = 6;
  localparam logic [2:0] LOCAL_STEP = 3'(N_SWEEP);
  localparam cfg_t       L1_INIT    = '0;
  localparam cfg_t       L2_INIT    = '{sz: FW'(L2_SIZE0), ln: FW'(L2_LINE0), wy: FW'(L2_WAYS0)};

  st_t           st;
  logic          hier;
  logic [2:0]    step;
  logic [4:0]    idx;
  cfg_t          best1, best2;
  logic [EW-1:0] best_e;
  cfg_t          cfg_q [4];
  logic          req_q, done_q;

  cfg_t                 cand1, cand2;
  logic                 over, range_ok, legal;
  cfg_t                 chk_c   [2];
  logic [N_SIZE*FW-1:0] chk_lim [2];
  logic                 chk_ok  [2];

  ct_cand_gen #(
    .N_SIZE(N_SIZE), .N_LINE(N_LINE), .N_WAYS(N_WAYS), .N_SWEEP(N_SWEEP)
  ) u_cand (
    .base1_i(best1), .base2_i(best2), .step_i(step), .idx_i(idx),
    .cand1_o(cand1), .cand2_o(cand2), .over_o(over), .range_ok_o(range_ok)
  );

  assign chk_c[0]   = cand1;
  assign chk_c[1]   = cand2;
  assign chk_lim[0] = l1_amax_i;
  assign chk_lim[1] = l2_amax_i;

  for (genvar g = 0; g < 2; g++) begin : g_lvl
    ct_legal_chk #(.N_SIZE(N_SIZE)) u_chk (
      .cfg_i(chk_c[g]), .amax_i(chk_lim[g]), .ok_o(chk_ok[g])
    );
  end

  assign legal = range_ok && chk_ok[0] && chk_ok[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      hier   <= 1'b0;
      step   <= '0;
      idx    <= '0;
      best1  <= L1_INIT;
      best2  <= L2_INIT;
      best_e <= '1;
      cfg_q[0] <= L1_INIT; cfg_q[1] <= L2_INIT;
      cfg_q[2] <= L1_INIT; cfg_q[3] <= L2_INIT;
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start_i) begin
          st     <= ST_PREP;
          hier   <= 1'b0;
          step   <= '0;
          idx    <= '0;
          best1  <= L1_INIT;
          best2  <= L2_INIT;
          best_e <= '1;
          done_q <= 1'b0;
          cfg_q[0] <= L1_INIT; cfg_q[1] <= L2_INIT;
          cfg_q[2] <= L1_INIT; cfg_q[3] <= L2_INIT;
        end
        ST_PREP: begin
          if (over) begin
            if (step == LOCAL_STEP) begin
              cfg_q[{hier, 1'b0}] <= best1;
              cfg_q[{hier, 1'b1}] <= best2;
              if (hier) begin
                st     <= ST_IDLE;
                done_q <= 1'b1;
              end else begin
                hier   <= 1'b1;
                step   <= '0;
                idx    <= '0;
                best1  <= L1_INIT;
                best2  <= L2_INIT;
                best_e <= '1;
              end
            end else begin
              step <= step + 3'd1;
              idx  <= '0;
            end
          end else if (!legal) begin
            idx <= idx + 5'd1;
          end else begin
            cfg_q[{hier, 1'b0}] <= cand1;
            cfg_q[{hier, 1'b1}] <= cand2;
            req_q <= 1'b1;
            st    <= ST_MEAS;
          end
        end
        ST_MEAS: if (energy_vld_i) begin
          req_q <= 1'b0;
          st    <= ST_PREP;
          if (energy_i < best_e) begin
            best_e <= energy_i;
            best1  <= cand1;
            best2  <= cand2;
          end
          if (step != LOCAL_STEP && energy_i > best_e) begin
            step <= step + 3'd1;
            idx  <= '0;
          end else begin
            idx <= idx + 5'd1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign l1i_cfg_o  = cfg_q[0];
  assign l2i_cfg_o  = cfg_q[1];
  assign l1d_cfg_o  = cfg_q[2];
  assign l2d_cfg_o  = cfg_q[3];
  assign meas_req_o = req_q;
  assign done_o     = done_q;

  // R2: an open request stays open until energy arrives
  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (meas_req_o && !energy_vld_i) |=> meas_req_o);

  // R2: words do not move while a measurement is pending
  p_cfg_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (meas_req_o && !energy_vld_i) |=> ($stable(l1i_cfg_o) && $stable(l2i_cfg_o)
                                       && $stable(l1d_cfg_o) && $stable(l2d_cfg_o)));

  // R8: data words rest at their start values while the instruction path is tuned
  p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && !hier) |-> (l1d_cfg_o == CW'(L1_INIT) && l2d_cfg_o == CW'(L2_INIT)));

  // R9: completion and an open request never coexist
  p_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !meas_req_o);

  // R6: within one path the best energy never rises
  p_best_mono_r6: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && $past(st) != ST_IDLE && hier == $past(hier)) |-> (best_e <= $past(best_e)));
endmodule

// File: tb/cache_tuner_tb_top.sv
`timescale 1ns/1ps
module cache_tuner_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start, vld;
  logic [31:0] energy;
  logic [7:0]  l1_amax, l2_amax;
  logic [5:0]  l1i, l2i, l1d, l2d;
  logic        req, done;

  always #2.5 clk = ~clk;

  cache_tuner dut_i (
    .clk(clk), .rst(rst), .start_i(start), .energy_i(energy), .energy_vld_i(vld),
    .l1_amax_i(l1_amax), .l2_amax_i(l2_amax),
    .l1i_cfg_o(l1i), .l2i_cfg_o(l2i), .l1d_cfg_o(l1d), .l2d_cfg_o(l2d),
    .meas_req_o(req), .done_o(done)
  );

  localparam logic [5:0] L2I = 6'b10_10_10;
  localparam int NSCN = 5;
  // {flat, l2 limits, l1 limits, targets l1{sz,ln,wy} l2{sz,ln,wy}}
  localparam logic [28:0] SCN [NSCN] = '{
    {1'b0, 8'hAA,        8'b10_10_01_00, 12'b10_01_10_11_10_01},
    {1'b0, 8'hAA,        8'hAA,          12'b00_00_00_00_00_00},
    {1'b0, 8'b10_10_01_00, 8'b10_01_00_00, 12'b11_10_10_11_10_10},
    {1'b1, 8'hAA,        8'hAA,          12'b00_00_00_00_00_00},
    {1'b0, 8'hAA,        8'hAA,          12'b01_10_00_01_00_10}
  };

  int errs = 0, checks = 0;
  logic [23:0] exp_w [80];
  int          exp_h [80];
  int          exp_n;
  logic [23:0] exp_fin;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", what, act, expv);
    end
  endtask

  function automatic logic [5:0] fset(input logic [5:0] c, input int f, input int v);
    logic [5:0] r = c;
    r[5-2*f -: 2] = 2'(v);
    return r;
  endfunction

  function automatic bit legal_b(input logic [7:0] am, input logic [5:0] c);
    return c[1:0] <= am[2*c[5:4] +: 2];
  endfunction

  function automatic logic [31:0] nrg(input int s, input int h, input logic [5:0] c1, input logic [5:0] c2);
    int w [6] = '{40, 20, 10, 20, 10, 5};
    int e = 1000;
    if (SCN[s][28]) return 32'd500;
    for (int f = 0; f < 6; f++) begin
      int v = (f < 3) ? int'(c1[5-2*(f%3) -: 2]) : int'(c2[5-2*(f%3) -: 2]);
      int t = int'(SCN[s][11-2*f -: 2]);
      if (h == 1) t = t ^ 1;
      e += w[f] * (v - t) * (v - t);
    end
    return 32'(e);
  endfunction

  task automatic rec(input int h, input logic [5:0] c1, c2, f1, f2);
    exp_w[exp_n] = (h == 0) ? {c1, c2, 6'd0, L2I} : {f1, f2, c1, c2};
    exp_h[exp_n] = h;
    exp_n++;
  endtask

  // independent model of the search (R3..R8)
  task automatic ref_run(input int s);
    logic [7:0] a1 = SCN[s][19:12], a2 = SCN[s][27:20];
    logic [5:0] b1, b2, c1, c2, f1, f2;
    logic [31:0] be, e;
    int cnt [3] = '{4, 3, 3};
    exp_n = 0; f1 = 6'd0; f2 = L2I;
    for (int h = 0; h < 2; h++) begin
      b1 = 6'd0; b2 = L2I; be = 32'hFFFF_FFFF;
      for (int st = 0; st < 6; st++) begin
        for (int v = 0; v < cnt[st/2]; v++) begin
          bit stop;
          c1 = b1; c2 = b2;
          if (st % 2 == 0) c1 = fset(c1, st/2, v); else c2 = fset(c2, st/2, v);
          if (!(legal_b(a1, c1) && legal_b(a2, c2))) continue;
          rec(h, c1, c2, f1, f2);
          e = nrg(s, h, c1, c2);
          stop = (e > be);
          if (e < be) begin be = e; b1 = c1; b2 = c2; end
          if (stop) break;
        end
      end
      for (int k = 0; k < 16; k++) begin
        logic [5:0] c = (k >= 8) ? b2 : b1;
        int mv = (k / 2) % 4;
        int d = (k % 2 == 1) ? 1 : -1;
        int sz = int'(c[5:4]), ln = int'(c[3:2]), wy = int'(c[1:0]);
        if (mv == 0 || mv == 3) sz += d;
        if (mv == 1) ln += d;
        if (mv == 2 || mv == 3) wy += d;
        if (sz < 0 || sz > 3 || ln < 0 || ln > 2 || wy < 0 || wy > 2) continue;
        c = {2'(sz), 2'(ln), 2'(wy)};
        c1 = b1; c2 = b2;
        if (k >= 8) c2 = c; else c1 = c;
        if (!(legal_b(a1, c1) && legal_b(a2, c2))) continue;
        rec(h, c1, c2, f1, f2);
        e = nrg(s, h, c1, c2);
        if (e < be) begin be = e; b1 = c1; b2 = c2; end
      end
      if (h == 0) begin f1 = b1; f2 = b2; end
      else exp_fin = {f1, f2, b1, b2};
    end
  endtask

  task automatic run_scn(input int s, input bit slow, input bit noise, input bit restart);
    int n = 0;
    int guard;
    int h;
    logic [23:0] w;
    l1_amax = SCN[s][19:12];
    l2_amax = SCN[s][27:20];
    ref_run(s);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    forever begin
      guard = 0;
      while (!req && !done && guard < 2000) begin @(negedge clk); guard++; end
      if (guard >= 2000) begin
        chk("R9 search stalled", 32'd0, 32'd1);
        return;
      end
      if (done) break;
      w = {l1i, l2i, l1d, l2d};
      if (n < exp_n) chk($sformatf("R3 R4 R5 R7 R8 scn%0d candidate %0d", s, n), 32'(w), 32'(exp_w[n]));
      else chk($sformatf("R4 scn%0d extra request", s), 32'(n), 32'(exp_n));
      h = (n < exp_n) ? exp_h[n] : 1;
      if (slow && n == 2) begin
        repeat (4) @(negedge clk);
        chk("R2 request held", 32'(req), 32'd1);
        chk("R2 words stable", 32'({l1i, l2i, l1d, l2d}), 32'(w));
      end
      if (restart && n == 3) begin
        start = 1'b1; @(negedge clk); start = 1'b0;
      end
      energy = (h == 1) ? nrg(s, 1, l1d, l2d) : nrg(s, 0, l1i, l2i);
      vld = 1'b1;
      @(negedge clk) vld = 1'b0;
      if (noise) begin
        energy = 32'd0; vld = 1'b1;
        @(negedge clk) vld = 1'b0;
      end
      n++;
    end
    chk($sformatf("R4 R5 scn%0d request count", s), 32'(n), 32'(exp_n));
    chk($sformatf("R6 R9 scn%0d final words", s), 32'({l1i, l2i, l1d, l2d}), 32'(exp_fin));
    chk($sformatf("R9 scn%0d done", s), 32'(done), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog R9 act=running exp=finished");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    start = 1'b0; vld = 1'b0; energy = 32'd0; l1_amax = 8'hAA; l2_amax = 8'hAA;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", 32'({req, done}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 req/done after reset", 32'({req, done}), 32'd0);
    chk("R1 words after reset", 32'({l1i, l2i, l1d, l2d}), 32'({6'd0, L2I, 6'd0, L2I}));
    // R2: a valid pulse with no open request is ignored
    energy = 32'd0; vld = 1'b1;
    @(negedge clk) vld = 1'b0;
    @(negedge clk);
    chk("R2 idle valid ignored", 32'({req, done, l1i, l2i, l1d, l2d}), 32'({2'b00, 6'd0, L2I, 6'd0, L2I}));
    for (int s = 0; s < NSCN; s++) run_scn(s, s == 1, s == 4, s == 0);
    // R9: result persists
    repeat (8) @(negedge clk);
    chk("R9 done persists", 32'(done), 32'd1);
    chk("R9 words persist", 32'({l1i, l2i, l1d, l2d}), 32'(exp_fin));
    // R8: a new start clears done and restores start words
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R9 done cleared by start", 32'(done), 32'd0);
    chk("R8 words restored by start", 32'({l1i, l2i, l1d, l2d}), 32'({6'd0, L2I, 6'd0, L2I}));
    // R1: reset in the middle of a search
    repeat (6) @(negedge clk);
    vld = 1'b0;
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset req/done", 32'({req, done}), 32'd0);
    chk("R1 mid-run reset words", 32'({l1i, l2i, l1d, l2d}), 32'({6'd0, L2I, 6'd0, L2I}));
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule